// File: doc/BRIEF.md
# Strap/Register Configuration Source Arbiter

This block sits between the strap pins of an eight-channel signal conditioner and its analog channel controls. For every channel it chooses where four settings come from: equalization, output amplitude, input termination and signal-detect threshold. The source is either the strap pins or a small register file that a management bus engine writes through a simple write/read port. Each strap arrives already resolved to one of four levels, coded 0 = `2'b00`, R = `2'b01`, F = `2'b10` and 1 = `2'b11`. Every effective setting on the outputs uses the same 2-bit code.

When `reg_mode` is low, the block is in strap mode. The lower half of the channels (group A) takes equalization and amplitude from the A straps, and the upper half (group B) takes them from the B straps. Termination and threshold come from their own straps. When `reg_mode` goes high, each channel has its own register. These registers are seeded from the straps on the entry cycle, so the outputs do not glitch.

A global enable bit guards every register change. The termination and threshold straps stay in control until a sticky override bit hands each of them to the registers. In register mode the four equalization and amplitude straps are reused as management bus address bits. Power-down only switches the channels off and leaves all register state alone.

Top module: `cfg_source_arbiter`

## Requirements
- R1: Synchronous active-high reset clears the enable bit, both override bits and every channel register to zero. After reset, reading address 0x06 or any channel address returns 0.
- R2: In strap mode, channels 0..NCH/2-1 take equalization from `strap_eq_a` and amplitude from `strap_amp_a`, and the other channels take them from `strap_eq_b` and `strap_amp_b`. Every channel's termination follows `strap_rxdet` and its threshold follows `strap_sdth`. Writes in strap mode are ignored.
- R3: On the first cycle `reg_mode` is high, every channel register loads the strap-derived values of its channel. Equalization and amplitude outputs keep the strap values through that cycle and show the register values afterwards.
- R4: Channel n's register sits at address 0x08+n, with equalization in bits [1:0], amplitude in [3:2], termination in [5:4] and threshold in [7:6]. A write to it is ignored while the enable bit (bit 3 of address 0x06) is 0.
- R5: With the enable bit set, a channel write changes only that channel. The new value appears on the outputs and on read-back from the next cycle on.
- R6: In register mode `bus_id` is {strap_amp_b[1], strap_amp_a[1], strap_eq_b[1], strap_eq_a[1]}, with bit 0 from `strap_eq_a`. In strap mode `bus_id` is 0.
- R7: In register mode, termination follows `strap_rxdet` and threshold follows `strap_sdth` until override bit 0 (termination) or bit 1 (threshold) of address 0x06 is written as 1 while the enable bit was already 1. From then on the channel register fields drive them.
- R8: Override bits are sticky in register mode: writing 0 to them does not clear them, and changes on the overridden strap have no effect.
- R9: When `reg_mode` falls, the enable bit, the overrides and all channel registers clear, and every output returns to the straps. A later re-entry starts again with no overrides.
- R10: `chan_on` is the inverse of `pwr_down` on every channel. Power-down changes no register and no effective setting, and it does not block writes.
- R11: Address 0x07 reads the live `sig_det` vector (bit n = channel n). Address 0x06 reads the enable bit in bit 3 and the overrides in bits 1 and 0. Unmapped addresses read 0. Reads work in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_mode | input | 1 | 1 = register mode, 0 = strap mode |
| pwr_down | input | 1 | Channel power-down |
| strap_eq_a | input | 2 | Group A equalization strap level |
| strap_eq_b | input | 2 | Group B equalization strap level |
| strap_amp_a | input | 2 | Group A amplitude strap level |
| strap_amp_b | input | 2 | Group B amplitude strap level |
| strap_rxdet | input | 2 | Termination strap level |
| strap_sdth | input | 2 | Signal-detect threshold strap level |
| sig_det | input | NCH | Per-channel signal-detect status |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| eq_out | output | 2*NCH | Effective equalization, channel n at [2n+1:2n] |
| amp_out | output | 2*NCH | Effective amplitude |
| term_out | output | 2*NCH | Effective termination |
| sdth_out | output | 2*NCH | Effective signal-detect threshold |
| chan_on | output | NCH | Channel enable |
| bus_id | output | 4 | Management bus address bits |

## Verification
A wrong enable or override bit shows on the ports through two paths. It appears on the next read of address 0x06. It also appears on `term_out` or `sdth_out` in the first cycle after the related strap is moved, which the sequence does on purpose. A register that was seeded or cleared wrongly shows on `eq_out`/`amp_out` in the cycle after the mode edge, since the straps are changed straight after entry. A channel register corrupted by a gated write shows on its outputs one cycle later. The bench compares every output against its reference model on every clock, so any such fault is caught within one cycle of first becoming visible.

// File: rtl/cfg_arb_pkg.sv
package cfg_arb_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_0 = 2'b00;
    localparam lvl_t LVL_R = 2'b01;
    localparam lvl_t LVL_F = 2'b10;
    localparam lvl_t LVL_1 = 2'b11;

    // Per-channel setting word; field order is the register layout.
    typedef struct packed {
        lvl_t sdth;
        lvl_t term;
        lvl_t amp;
        lvl_t eq;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        lvl_t eq_a;
        lvl_t eq_b;
        lvl_t amp_a;
        lvl_t amp_b;
        lvl_t rxdet;
        lvl_t sdth;
    } strap_t;

    localparam int CTRL_ADDR    = 8'h06;
    localparam int STAT_ADDR    = 8'h07;
    localparam int CH_BASE      = 8'h08;
    localparam int EN_BIT       = 3;
    localparam int OVR_TERM_BIT = 0;
    localparam int OVR_SDTH_BIT = 1;

    // A strap used as an address bit reads high for levels F and 1.
    function automatic logic lvl_to_bit(lvl_t l);
        return l[1];
    endfunction

endpackage

// File: rtl/strap_decode.sv
module strap_decode
    import cfg_arb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  strap_t                straps,
    output chan_cfg_t [NCH-1:0]   pin_cfg,
    output logic      [3:0]       addr_bits
);

    localparam int HALF = NCH / 2;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i < HALF) begin : g_grp_a
            assign pin_cfg[i].eq  = straps.eq_a;
            assign pin_cfg[i].amp = straps.amp_a;
        end else begin : g_grp_b
            assign pin_cfg[i].eq  = straps.eq_b;
            assign pin_cfg[i].amp = straps.amp_b;
        end
        assign pin_cfg[i].term = straps.rxdet;
        assign pin_cfg[i].sdth = straps.sdth;
    end

    assign addr_bits = {lvl_to_bit(straps.amp_b), lvl_to_bit(straps.amp_a),
                        lvl_to_bit(straps.eq_b),  lvl_to_bit(straps.eq_a)};

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_arb_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode,
    input  chan_cfg_t [NCH-1:0]   pin_cfg,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NCH-1:0]        sig_det,
    output chan_cfg_t [NCH-1:0]   chans,
    output logic                  reg_en,
    output logic                  ovr_term,
    output logic                  ovr_sdth,
    output logic                  mode_rise,
    output logic [DATA_W-1:0]     rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic      mode_q;
    logic      mode_fall;
    logic      wr_live;
    logic      ctrl_hit;
    chan_cfg_t regs_q [NCH];

    assign mode_rise = mode & ~mode_q;
    assign mode_fall = mode_q & ~mode;
    assign wr_live   = wr & mode & ~mode_rise;
    assign ctrl_hit  = wr_live && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= mode;
    end

    always_ff @(posedge clk) begin
        if (rst || mode_fall) begin
            reg_en   <= 1'b0;
            ovr_term <= 1'b0;
            ovr_sdth <= 1'b0;
        end else if (ctrl_hit) begin
            reg_en <= wdata[EN_BIT];
            if (reg_en) begin
                ovr_term <= ovr_term | wdata[OVR_TERM_BIT];
                ovr_sdth <= ovr_sdth | wdata[OVR_SDTH_BIT];
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(CH_BASE + i);
        logic hit;
        assign hit = wr_live && reg_en && (addr == A_CH);

        always_ff @(posedge clk) begin
            if (rst || mode_fall)  regs_q[i] <= '0;
            else if (mode_rise)    regs_q[i] <= pin_cfg[i];
            else if (hit)          regs_q[i] <= chan_cfg_t'(wdata[CFG_W-1:0]);
        end

        assign chans[i] = regs_q[i];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[EN_BIT]       = reg_en;
            rdata[OVR_TERM_BIT] = ovr_term;
            rdata[OVR_SDTH_BIT] = ovr_sdth;
        end else if (addr == A_STAT) begin
            rdata[NCH-1:0] = sig_det;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == ADDR_W'(CH_BASE + i)) rdata[CFG_W-1:0] = regs_q[i];
            end
        end
    end

    // R4: a channel write with the enable bit low leaves every register alone
    assert_write_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_live && !reg_en && mode && mode_q) |=> $stable(chans));

    // R7: an override can only appear when the enable bit was already set
    assert_ovr_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(ovr_term) || $rose(ovr_sdth)) |-> $past(reg_en));

    // R8: overrides stay set for as long as register mode lasts
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (mode && ovr_term) |=> ovr_term);

    // R9: leaving register mode drops the enable bit and all overrides
    assert_fall_clear_R9: assert property (@(posedge clk) disable iff (rst)
        mode_fall |=> (!reg_en && !ovr_term && !ovr_sdth));

endmodule

// File: rtl/cfg_select.sv
module cfg_select
    import cfg_arb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode,
    input  logic                  mode_rise,
    input  logic                  ovr_term,
    input  logic                  ovr_sdth,
    input  chan_cfg_t [NCH-1:0]   pin_cfg,
    input  chan_cfg_t [NCH-1:0]   chans,
    output chan_cfg_t [NCH-1:0]   eff
);

    logic use_pins;
    logic reg_term;
    logic reg_sdth;

    assign use_pins = ~mode | mode_rise;
    assign reg_term = mode & ovr_term;
    assign reg_sdth = mode & ovr_sdth;

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        always_comb begin
            eff[i].eq   = use_pins ? pin_cfg[i].eq   : chans[i].eq;
            eff[i].amp  = use_pins ? pin_cfg[i].amp  : chans[i].amp;
            eff[i].term = reg_term ? chans[i].term   : pin_cfg[i].term;
            eff[i].sdth = reg_sdth ? chans[i].sdth   : pin_cfg[i].sdth;
        end
    end

    // R3: across mode entry, steady straps give steady equalization/amplitude
    assert_no_glitch_R3: assert property (@(posedge clk) disable iff (rst)
        mode_rise |=> (!mode || !$stable(pin_cfg) || $stable(eff)));

endmodule

// File: rtl/cfg_source_arbiter.sv
module cfg_source_arbiter
    import cfg_arb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_mode,
    input  logic               pwr_down,
    input  logic [1:0]         strap_eq_a,
    input  logic [1:0]         strap_eq_b,
    input  logic [1:0]         strap_amp_a,
    input  logic [1:0]         strap_amp_b,
    input  logic [1:0]         strap_rxdet,
    input  logic [1:0]         strap_sdth,
    input  logic [NCH-1:0]     sig_det,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [2*NCH-1:0]   eq_out,
    output logic [2*NCH-1:0]   amp_out,
    output logic [2*NCH-1:0]   term_out,
    output logic [2*NCH-1:0]   sdth_out,
    output logic [NCH-1:0]     chan_on,
    output logic [3:0]         bus_id
);

    strap_t               straps;
    chan_cfg_t [NCH-1:0]  pin_cfg;
    chan_cfg_t [NCH-1:0]  chans;
    chan_cfg_t [NCH-1:0]  eff;
    logic [3:0]           addr_bits;
    logic                 reg_en;
    logic                 ovr_term;
    logic                 ovr_sdth;
    logic                 mode_rise;

    assign straps = '{eq_a: strap_eq_a, eq_b: strap_eq_b, amp_a: strap_amp_a,
                      amp_b: strap_amp_b, rxdet: strap_rxdet, sdth: strap_sdth};

    strap_decode #(.NCH(NCH)) u_dec (
        .straps    (straps),
        .pin_cfg   (pin_cfg),
        .addr_bits (addr_bits)
    );

    cfg_regfile #(.NCH(NCH), .ADDR_W(8), .DATA_W(8)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .mode      (reg_mode),
        .pin_cfg   (pin_cfg),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .sig_det   (sig_det),
        .chans     (chans),
        .reg_en    (reg_en),
        .ovr_term  (ovr_term),
        .ovr_sdth  (ovr_sdth),
        .mode_rise (mode_rise),
        .rdata     (bus_rdata)
    );

    cfg_select #(.NCH(NCH)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .mode      (reg_mode),
        .mode_rise (mode_rise),
        .ovr_term  (ovr_term),
        .ovr_sdth  (ovr_sdth),
        .pin_cfg   (pin_cfg),
        .chans     (chans),
        .eff       (eff)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_flat
        assign eq_out[2*i +: 2]   = eff[i].eq;
        assign amp_out[2*i +: 2]  = eff[i].amp;
        assign term_out[2*i +: 2] = eff[i].term;
        assign sdth_out[2*i +: 2] = eff[i].sdth;
    end

    assign chan_on = ~{NCH{pwr_down}};
    assign bus_id  = reg_mode ? addr_bits : 4'b0000;

    // R2: in strap mode the outermost channels follow their group straps
    assert_pin_group_R2: assert property (@(posedge clk) disable iff (rst)
        !reg_mode |-> (eq_out[1:0] == strap_eq_a && eq_out[2*NCH-1 -: 2] == strap_eq_b
                       && amp_out[1:0] == strap_amp_a));

    // R6: no address bits are presented while in strap mode
    assert_id_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !reg_mode |-> (bus_id == 4'b0000));

endmodule

// File: tb/cfg_source_arbiter_test.sv
`timescale 1ns/1ps
module cfg_source_arbiter_test;

    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_mode = 1'b0, pwr_down = 1'b0;
    logic [1:0] s_eq_a = 0, s_eq_b = 0, s_amp_a = 0, s_amp_b = 0, s_rxdet = 0, s_sdth = 0;
    logic [NCH-1:0] sig_det = '0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2*NCH-1:0] eq_out, amp_out, term_out, sdth_out;
    logic [NCH-1:0] chan_on;
    logic [3:0] bus_id;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    // reference model state
    bit m_mq = 0, m_en = 0, m_ot = 0, m_os = 0;
    int m_ch [NCH];

    always #10 clk = ~clk;

    cfg_source_arbiter #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .reg_mode(reg_mode), .pwr_down(pwr_down),
        .strap_eq_a(s_eq_a), .strap_eq_b(s_eq_b), .strap_amp_a(s_amp_a),
        .strap_amp_b(s_amp_b), .strap_rxdet(s_rxdet), .strap_sdth(s_sdth),
        .sig_det(sig_det), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eq_out(eq_out),
        .amp_out(amp_out), .term_out(term_out), .sdth_out(sdth_out),
        .chan_on(chan_on), .bus_id(bus_id)
    );

    function automatic int pin_word(int ch);
        int eq, amp;
        eq  = (ch < NCH/2) ? s_eq_a  : s_eq_b;
        amp = (ch < NCH/2) ? s_amp_a : s_amp_b;
        return (int'(s_sdth) << 6) | (int'(s_rxdet) << 4) | (amp << 2) | eq;
    endfunction

    task automatic model_update();
        bit rise, fall;
        if (rst) begin
            m_mq = 0; m_en = 0; m_ot = 0; m_os = 0;
            foreach (m_ch[i]) m_ch[i] = 0;
            return;
        end
        rise = reg_mode && !m_mq;
        fall = m_mq && !reg_mode;
        if (fall) begin
            m_en = 0; m_ot = 0; m_os = 0;
            foreach (m_ch[i]) m_ch[i] = 0;
        end else if (rise) begin
            foreach (m_ch[i]) m_ch[i] = pin_word(i);
        end else if (bus_wr && reg_mode) begin
            if (bus_addr == 8'h06) begin
                if (m_en) begin
                    m_ot = m_ot | bus_wdata[0];
                    m_os = m_os | bus_wdata[1];
                end
                m_en = bus_wdata[3];
            end else if (bus_addr >= 8'h08 && bus_addr < 8'h08 + NCH && m_en) begin
                m_ch[bus_addr - 8'h08] = bus_wdata;
            end
        end
        m_mq = reg_mode;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit rise;
        logic [2*NCH-1:0] e_eq, e_amp, e_term, e_sdth;
        int e_rd;
        rise = reg_mode && !m_mq;
        for (int i = 0; i < NCH; i++) begin
            int pw, src;
            pw = pin_word(i);
            src = (!reg_mode || rise) ? pw : m_ch[i];
            e_eq[2*i +: 2]  = 2'(src);
            e_amp[2*i +: 2] = 2'(src >> 2);
            e_term[2*i +: 2] = 2'(((reg_mode && m_ot) ? m_ch[i] : pw) >> 4);
            e_sdth[2*i +: 2] = 2'(((reg_mode && m_os) ? m_ch[i] : pw) >> 6);
        end
        if (bus_addr == 8'h06)      e_rd = (int'(m_en) << 3) | (int'(m_os) << 1) | int'(m_ot);
        else if (bus_addr == 8'h07) e_rd = sig_det;
        else if (bus_addr >= 8'h08 && bus_addr < 8'h08 + NCH) e_rd = m_ch[bus_addr - 8'h08];
        else e_rd = 0;
        chk(phase, "eq_out", eq_out, e_eq);
        chk(phase, "amp_out", amp_out, e_amp);
        chk(phase, "term_out", term_out, e_term);
        chk(phase, "sdth_out", sdth_out, e_sdth);
        chk(phase, "chan_on", chan_on, pwr_down ? 0 : {NCH{1'b1}});
        chk(phase, "bus_id", bus_id,
            reg_mode ? {s_amp_b[1], s_amp_a[1], s_eq_b[1], s_eq_a[1]} : 0);
        chk(phase, "bus_rdata", bus_rdata, e_rd);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_reg(int a, int d);
        bus_wr = 1; bus_addr = 8'(a); bus_wdata = 8'(d);
        tick();
        bus_wr = 0;
    endtask

    task automatic rd_chk(string tag, int a, int exp);
        bus_addr = 8'(a);
        tick();
        chk(tag, "readback", bus_rdata, exp);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;

        phase = "R1";
        rd_chk("R1", 8'h06, 0);
        rd_chk("R1", 8'h08, 0);

        phase = "R2";
        s_eq_a = 1; s_eq_b = 2; s_amp_a = 3; s_amp_b = 0; s_rxdet = 2; s_sdth = 1;
        tick();
        chk("R2", "eq grouping", eq_out, 16'hAA55);
        chk("R2", "amp grouping", amp_out, 16'h00FF);
        chk("R2", "term strap", term_out, 16'hAAAA);
        chk("R2", "sdth strap", sdth_out, 16'h5555);
        s_eq_a = 3;
        tick();
        chk("R2", "eq group A change", eq_out, 16'hAAFF);
        wr_reg(8'h06, 8'h08);
        rd_chk("R2", 8'h06, 0);

        phase = "R3";
        reg_mode = 1;
        tick();
        chk("R3", "eq on entry cycle", eq_out, 16'hAAFF);
        s_eq_a = 0; s_amp_b = 2;
        tick();
        chk("R3", "eq held from seed", eq_out, 16'hAAFF);
        chk("R3", "amp held from seed", amp_out, 16'h00FF);

        phase = "R6";
        tick();
        chk("R6", "bus_id", bus_id, 4'b1110);

        phase = "R4";
        wr_reg(8'h09, 8'hFF);
        rd_chk("R4", 8'h09, 8'h6F);

        phase = "R7";
        wr_reg(8'h06, 8'h0B);
        rd_chk("R7", 8'h06, 8'h08);
        s_rxdet = 1;
        tick();
        chk("R7", "term follows strap", term_out, 16'h5555);

        phase = "R5";
        for (int n = 0; n < NCH; n++) wr_reg(8'h08 + n, (n * 37 + 5) & 8'hFF);
        for (int n = 0; n < NCH; n++) rd_chk("R5", 8'h08 + n, (n * 37 + 5) & 8'hFF);
        wr_reg(8'h0A, 8'hC6);
        chk("R5", "ch2 eq", eq_out[5:4], 2'b10);
        chk("R5", "ch1 eq untouched", eq_out[3:2], 2'b10);

        phase = "R7";
        wr_reg(8'h06, 8'h0B);
        rd_chk("R7", 8'h06, 8'h0B);
        chk("R7", "ch2 term from reg", term_out[5:4], 2'b00);

        phase = "R8";
        s_rxdet = 3; s_sdth = 3;
        tick();
        chk("R8", "ch2 sdth ignores strap", sdth_out[5:4], 2'b11);
        chk("R8", "ch2 term ignores strap", term_out[5:4], 2'b00);
        wr_reg(8'h06, 8'h08);
        rd_chk("R8", 8'h06, 8'h0B);
        wr_reg(8'h06, 8'h00);
        rd_chk("R8", 8'h06, 8'h03);
        wr_reg(8'h0A, 8'h00);
        rd_chk("R8", 8'h0A, 8'hC6);

        phase = "R10";
        pwr_down = 1;
        tick();
        chk("R10", "chan_on off", chan_on, 0);
        wr_reg(8'h06, 8'h08);
        wr_reg(8'h0B, 8'h12);
        rd_chk("R10", 8'h0A, 8'hC6);
        pwr_down = 0;
        rd_chk("R10", 8'h0B, 8'h12);

        phase = "R11";
        sig_det = 8'hA5;
        rd_chk("R11", 8'h07, 8'hA5);
        sig_det = 8'h3C;
        rd_chk("R11", 8'h07, 8'h3C);
        rd_chk("R11", 8'h30, 0);

        phase = "R9";
        reg_mode = 0;
        tick();
        rd_chk("R9", 8'h06, 0);
        rd_chk("R9", 8'h0B, 0);
        reg_mode = 1;
        tick();
        s_rxdet = 0;
        tick();
        chk("R9", "term back on strap", term_out, 16'h0000);
        rd_chk("R9", 8'h06, 0);

        phase = "R1";
        wr_reg(8'h06, 8'h08);
        wr_reg(8'h08, 8'h33);
        rst = 1;
        tick(); tick();
        rst = 0;
        rd_chk("R1", 8'h06, 0);
        tick();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule